// File: doc/BRIEF.md
# Processor Status Register with Delayed Fields

This block holds the processor status word of a windowed-register integer core. The word packs the condition codes, the interrupt priority level, the privilege bit, its saved copy, the trap-enable bit and the current window pointer, together with two read-only identification nibbles. Software writes a full 32-bit word, the ALU updates the condition codes directly, and the trap sequencer raises a trap-entry or trap-return pulse. The core reads the committed word on `psr_out`.

The condition codes and the interrupt level change at the clock edge that samples the update. The control group (privilege, saved privilege, trap enable and window pointer) does not. A software write places it in a pending buffer, and it commits a fixed number of edges later (`COMMIT_LAT`, three by default). A newer write that arrives before the commit replaces the pending value and restarts the count. Trap entry and trap return change the control group at once and discard anything still pending. Logic such as the window-save path therefore sees only committed values.

Top module: `psr_status_reg`

## Requirements
- R1: After reset `psr_out` is 0xA300_0080: identification nibbles A and 3, condition codes 0, interrupt level 0, privilege 1, saved privilege 0, trap enable 0, window pointer 0.
- R2: A write with `wr_en` high loads `wr_data[23:20]` into the condition codes (n,z,v,c from bit 23 down to bit 20) at the sampling edge. A write takes priority over an ALU update in the same cycle.
- R3: With `wr_en` low, `icc_we` high loads `icc_in` into `psr_out[23:20]` at the sampling edge. With both low the codes hold.
- R4: A write loads `wr_data[11:8]` into the interrupt level `psr_out[11:8]` at the sampling edge. Nothing else changes the level.
- R5: A write's control group (privilege bit 7, saved privilege bit 6, trap enable bit 5, window pointer bits 4:0) leaves `psr_out[7:0]` unchanged at the sampling edge and at the next COMMIT_LAT-1 edges. It appears at edge COMMIT_LAT after the write.
- R6: A write made while an earlier one is still pending discards the earlier value, which never appears. The newer value commits COMMIT_LAT edges after its own write.
- R7: At the edge that samples `trap_enter`, the word takes privilege 1, trap enable 0, saved privilege equal to the prior privilege bit, and window pointer (prior − 1) modulo NWIN. Any pending control write is discarded.
- R8: At the edge that samples `trap_return` (without `trap_enter`), privilege takes the saved-privilege bit, trap enable becomes 1, and the window pointer becomes (prior + 1) modulo NWIN. Saved privilege holds and any pending control write is discarded.
- R9: Bits 31:28 always read IMPL_ID and bits 27:24 always read VER_ID. Bits 19:12 read zero. A written window pointer keeps only its low log2(NWIN) bits, so the pointer reads below NWIN.
- R10: When `trap_enter`, `trap_return` and `wr_en` are sampled together, trap entry sets the control group and the write's control group is dropped. The write's condition codes and level still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| icc_we | input | 1 | ALU condition-code update strobe |
| icc_in | input | 4 | ALU condition codes n,z,v,c (bit 3 down to bit 0) |
| trap_enter | input | 1 | Trap entry pulse |
| trap_return | input | 1 | Trap return pulse |
| psr_out | output | 32 | Committed status word |

## Verification
On every cycle the assertions check four things: the immediate loads of the condition codes and the level, the trap-entry and trap-return field rules including window wrap, and the fixed identification and zero bits. They also check that the control group moves only on a trap or on a commit. The commit value is tracked against a shadow countdown kept in the checker. Only the bench scenarios show the complete timelines: a restarted write whose first value never surfaces, a pending write cancelled by a trap, and the three-way collision of trap entry, trap return and a write.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int unsigned ICC_LSB = 20;
  localparam int unsigned PIL_LSB = 8;
  localparam int unsigned PRIV_BIT = 7;
  localparam int unsigned PPRIV_BIT = 6;
  localparam int unsigned TEN_BIT = 5;
  localparam int unsigned WPTR_W = 5;

  typedef struct packed {
    logic                priv;
    logic                ppriv;
    logic                ten;
    logic [WPTR_W-1:0]   wptr;
  } ctl_t;

endpackage

// File: rtl/psr_imm_fields.sv
module psr_imm_fields (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_icc,
  input  logic [3:0] wr_pil,
  input  logic       icc_we,
  input  logic [3:0] icc_in,
  output logic [3:0] icc_q,
  output logic [3:0] pil_q
);

  logic       icc_en;
  logic [3:0] icc_d;

  always_comb begin
    icc_en = wr_en | icc_we;
    icc_d  = wr_en ? wr_icc : icc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icc_q <= 4'h0;
    end else if (icc_en) begin
      icc_q <= icc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pil_q <= 4'h0;
    end else if (wr_en) begin
      pil_q <= wr_pil;
    end
  end

endmodule

// File: rtl/psr_pend_buf.sv
module psr_pend_buf
  import psr_pkg::*;
#(
  parameter int unsigned COMMIT_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  ctl_t load_val,
  input  logic flush,
  output logic commit_vld,
  output ctl_t commit_val
);

  localparam int unsigned CNT_W = $clog2(COMMIT_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_LAT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ctl_t             val_q;
  logic             cnt_en;
  logic             val_en;

  always_comb begin
    commit_vld = (cnt_q == CNT_ONE) && !flush;
    commit_val = val_q;
    val_en     = load && !flush;
    cnt_en     = flush || load || (cnt_q != '0);
    if (flush) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = CNT_LOAD;
    end else begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= load_val;
    end
  end

endmodule

// File: rtl/psr_ctl_fields.sv
module psr_ctl_fields
  import psr_pkg::*;
#(
  parameter int unsigned NWIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_enter,
  input  logic trap_return,
  input  logic commit_vld,
  input  ctl_t commit_val,
  output ctl_t ctl_q
);

  localparam logic [WPTR_W-1:0] WPTR_TOP = WPTR_W'(NWIN - 1);

  ctl_t              ctl_d;
  logic              ctl_en;
  logic [WPTR_W-1:0] wptr_dec;
  logic [WPTR_W-1:0] wptr_inc;

  always_comb begin
    wptr_dec = (ctl_q.wptr == '0) ? WPTR_TOP : ctl_q.wptr - WPTR_W'(1);
    wptr_inc = (ctl_q.wptr == WPTR_TOP) ? '0 : ctl_q.wptr + WPTR_W'(1);
    ctl_en   = trap_enter || trap_return || commit_vld;
    ctl_d    = ctl_q;
    if (trap_enter) begin
      ctl_d.priv  = 1'b1;
      ctl_d.ppriv = ctl_q.priv;
      ctl_d.ten   = 1'b0;
      ctl_d.wptr  = wptr_dec;
    end else if (trap_return) begin
      ctl_d.priv  = ctl_q.ppriv;
      ctl_d.ten   = 1'b1;
      ctl_d.wptr  = wptr_inc;
    end else begin
      ctl_d = commit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{priv: 1'b1, ppriv: 1'b0, ten: 1'b0, wptr: '0};
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
#(
  parameter int unsigned NWIN       = 8,
  parameter int unsigned COMMIT_LAT = 3,
  parameter logic [3:0]  IMPL_ID    = 4'hA,
  parameter logic [3:0]  VER_ID     = 4'h3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        icc_we,
  input  logic [3:0]  icc_in,
  input  logic        trap_enter,
  input  logic        trap_return,
  output logic [31:0] psr_out
);

  localparam int unsigned WIN_BITS = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [WPTR_W-1:0] WPTR_MASK = WPTR_W'((1 << WIN_BITS) - 1);

  logic        rst_meta_q;
  logic        rst_sync_n;
  logic [3:0]  icc_q;
  logic [3:0]  pil_q;
  ctl_t        wr_ctl;
  ctl_t        ctl_q;
  ctl_t        commit_val;
  logic        commit_vld;
  logic        flush;
  logic        unused_wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    wr_ctl.priv    = wr_data[PRIV_BIT];
    wr_ctl.ppriv   = wr_data[PPRIV_BIT];
    wr_ctl.ten     = wr_data[TEN_BIT];
    wr_ctl.wptr    = wr_data[WPTR_W-1:0] & WPTR_MASK;
    flush          = trap_enter | trap_return;
    unused_wr_bits = ^{wr_data[31:24], wr_data[19:12]};
  end

  psr_imm_fields u_imm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_icc (wr_data[ICC_LSB+3:ICC_LSB]),
    .wr_pil (wr_data[PIL_LSB+3:PIL_LSB]),
    .icc_we (icc_we),
    .icc_in (icc_in),
    .icc_q  (icc_q),
    .pil_q  (pil_q)
  );

  psr_pend_buf #(.COMMIT_LAT(COMMIT_LAT)) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (wr_en),
    .load_val   (wr_ctl),
    .flush      (flush),
    .commit_vld (commit_vld),
    .commit_val (commit_val)
  );

  psr_ctl_fields #(.NWIN(NWIN)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .trap_enter  (trap_enter),
    .trap_return (trap_return),
    .commit_vld  (commit_vld),
    .commit_val  (commit_val),
    .ctl_q       (ctl_q)
  );

  assign psr_out = {IMPL_ID, VER_ID, icc_q, 8'h00, pil_q,
                    ctl_q.priv, ctl_q.ppriv, ctl_q.ten, ctl_q.wptr};

endmodule

// File: rtl/psr_status_chk.sv
module psr_status_chk #(
  parameter int unsigned NWIN       = 8,
  parameter int unsigned COMMIT_LAT = 3,
  parameter logic [3:0]  IMPL_ID    = 4'hA,
  parameter logic [3:0]  VER_ID     = 4'h3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        icc_we,
  input logic [3:0]  icc_in,
  input logic        trap_enter,
  input logic        trap_return,
  input logic [31:0] psr_out
);

  localparam int unsigned CNT_W    = $clog2(COMMIT_LAT + 1);
  localparam int unsigned WIN_BITS = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [4:0]  WMASK    = 5'((1 << WIN_BITS) - 1);

  logic [CNT_W-1:0] age_q;
  logic [7:0]       shadow_q;
  logic             any_trap;
  logic             unused_chk_bits;

  assign any_trap        = trap_enter | trap_return;
  assign unused_chk_bits = ^{wr_data[31:24], wr_data[19:12]};

  function automatic logic [4:0] wdec(input logic [4:0] w);
    return (w == 5'd0) ? 5'(NWIN - 1) : w - 5'd1;
  endfunction

  function automatic logic [4:0] winc(input logic [4:0] w);
    return (w == 5'(NWIN - 1)) ? 5'd0 : w + 5'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (any_trap) begin
        age_q <= '0;
      end else if (wr_en) begin
        age_q <= CNT_W'(1);
      end else if (age_q == CNT_W'(COMMIT_LAT)) begin
        age_q <= '0;
      end else if (age_q != '0) begin
        age_q <= age_q + CNT_W'(1);
      end
      if (wr_en && !any_trap) begin
        shadow_q <= {wr_data[7:5], wr_data[4:0] & WMASK};
      end
    end
  end

  assert_icc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> psr_out[23:20] == $past(wr_data[23:20]));

  assert_icc_alu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (icc_we && !wr_en) |=> psr_out[23:20] == $past(icc_in));

  assert_icc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!icc_we && !wr_en) |=> $stable(psr_out[23:20]));

  assert_pil_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> psr_out[11:8] == $past(wr_data[11:8]));

  assert_pil_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(psr_out[11:8]));

  assert_ctl_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == CNT_W'(COMMIT_LAT) && !any_trap) |=> psr_out[7:0] == $past(shadow_q));

  assert_ctl_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != CNT_W'(COMMIT_LAT) && !any_trap) |=> $stable(psr_out[7:0]));

  assert_trap_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> (psr_out[7] == 1'b1) && (psr_out[5] == 1'b0) &&
                   (psr_out[6] == $past(psr_out[7])) &&
                   (psr_out[4:0] == wdec($past(psr_out[4:0]))));

  assert_trap_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_return && !trap_enter) |=> (psr_out[7] == $past(psr_out[6])) &&
                   (psr_out[5] == 1'b1) && $stable(psr_out[6]) &&
                   (psr_out[4:0] == winc($past(psr_out[4:0]))));

  assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_out[31:24] == {IMPL_ID, VER_ID}) && (psr_out[19:12] == 8'h00) &&
    (32'(psr_out[4:0]) < NWIN));

endmodule

bind psr_status_reg psr_status_chk #(
  .NWIN(NWIN), .COMMIT_LAT(COMMIT_LAT), .IMPL_ID(IMPL_ID), .VER_ID(VER_ID)
) u_psr_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .icc_we      (icc_we),
  .icc_in      (icc_in),
  .trap_enter  (trap_enter),
  .trap_return (trap_return),
  .psr_out     (psr_out)
);

// File: tb/test_psr_status_reg.sv
module test_psr_status_reg;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        icc_we;
  logic [3:0]  icc_in;
  logic        trap_enter;
  logic        trap_return;
  logic [31:0] psr_out;

  int n_chk;
  int n_fail;

  psr_status_reg i_psr_status_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .icc_we      (icc_we),
    .icc_in      (icc_in),
    .trap_enter  (trap_enter),
    .trap_return (trap_return),
    .psr_out     (psr_out)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [31:0] mk(input logic [3:0] icc, input logic [3:0] pil,
                                     input logic s, input logic ps, input logic et,
                                     input logic [4:0] cwp);
    return {4'hA, 4'h3, icc, 8'h00, pil, s, ps, et, cwp};
  endfunction

  function automatic logic [31:0] wd(input logic [3:0] icc, input logic [3:0] pil,
                                     input logic s, input logic ps, input logic et,
                                     input logic [4:0] cwp);
    return {8'hFF, icc, 8'hFF, pil, s, ps, et, cwp};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (psr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: psr_out=%h expected=%h", req, psr_out, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 1'b0; wr_data = '0; icc_we = 1'b0; icc_in = '0;
    trap_enter = 1'b0; trap_return = 1'b0;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic write(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset value", 32'hA300_0080);
  endtask

  task automatic t_imm_and_delay();
    do_reset();
    icc_we = 1'b1; icc_in = 4'h0;
    write(wd(4'hF, 4'hF, 1'b1, 1'b1, 1'b1, 5'h1F));
    icc_we = 1'b0;
    check("R2 R4 R9 immediate fields, write beats ALU", mk(4'hF, 4'hF, 1, 0, 0, 0));
    tick();
    check("R5 control group held one edge later", mk(4'hF, 4'hF, 1, 0, 0, 0));
    tick();
    check("R5 control group held two edges later", mk(4'hF, 4'hF, 1, 0, 0, 0));
    tick();
    check("R5 R9 control group committed, pointer truncated", mk(4'hF, 4'hF, 1, 1, 1, 7));
  endtask

  task automatic t_alu_icc();
    icc_we = 1'b1; icc_in = 4'h5;
    tick();
    icc_we = 1'b0; icc_in = 4'hA;
    check("R3 ALU update", mk(4'h5, 4'hF, 1, 1, 1, 7));
    tick();
    check("R3 codes hold without strobe", mk(4'h5, 4'hF, 1, 1, 1, 7));
  endtask

  task automatic t_restart();
    do_reset();
    write(wd(4'h0, 4'h2, 1'b0, 1'b1, 1'b1, 5'd2));
    check("R5 first write immediate part", mk(4'h0, 4'h2, 1, 0, 0, 0));
    tick();
    write(wd(4'h0, 4'h6, 1'b1, 1'b0, 1'b1, 5'd5));
    check("R6 second write before commit", mk(4'h0, 4'h6, 1, 0, 0, 0));
    tick();
    check("R6 superseded value never appears", mk(4'h0, 4'h6, 1, 0, 0, 0));
    tick();
    check("R6 newer value still pending", mk(4'h0, 4'h6, 1, 0, 0, 0));
    tick();
    check("R6 newer value committed", mk(4'h0, 4'h6, 1, 0, 1, 5));
  endtask

  task automatic t_trap_entry();
    do_reset();
    write(wd(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 5'd5));
    tick(); tick(); tick();
    check("R5 setup commit", mk(4'h0, 4'h0, 1, 0, 1, 5));
    write(wd(4'h0, 4'h4, 1'b0, 1'b1, 1'b1, 5'd2));
    trap_enter = 1'b1;
    tick();
    trap_enter = 1'b0;
    check("R7 trap entry fields", mk(4'h0, 4'h4, 1, 1, 0, 4));
    tick(); tick(); tick();
    check("R7 pending write discarded by trap entry", mk(4'h0, 4'h4, 1, 1, 0, 4));
    do_reset();
    trap_enter = 1'b1;
    tick();
    trap_enter = 1'b0;
    check("R7 window pointer wraps downward", mk(4'h0, 4'h0, 1, 1, 0, 7));
  endtask

  task automatic t_trap_return();
    do_reset();
    write(wd(4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 5'd3));
    trap_return = 1'b1;
    tick();
    trap_return = 1'b0;
    check("R8 trap return fields", mk(4'h0, 4'h0, 0, 0, 1, 1));
    tick(); tick(); tick();
    check("R8 pending write discarded by trap return", mk(4'h0, 4'h0, 0, 0, 1, 1));
    do_reset();
    write(wd(4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 5'd7));
    tick(); tick(); tick();
    check("R5 setup commit before return", mk(4'h0, 4'h0, 1, 0, 0, 7));
    trap_return = 1'b1;
    tick();
    trap_return = 1'b0;
    check("R8 window pointer wraps upward", mk(4'h0, 4'h0, 0, 0, 1, 0));
  endtask

  task automatic t_collision();
    write(wd(4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 5'd3));
    wr_en = 1'b1; wr_data = wd(4'h3, 4'h9, 1'b0, 1'b1, 1'b1, 5'd6);
    trap_enter = 1'b1; trap_return = 1'b1;
    tick();
    wr_en = 1'b0; wr_data = '0;
    trap_enter = 1'b0; trap_return = 1'b0;
    check("R10 trap entry wins, write immediate part kept", mk(4'h3, 4'h9, 1, 0, 0, 7));
    tick(); tick(); tick(); tick();
    check("R10 dropped control write never commits", mk(4'h3, 4'h9, 1, 0, 0, 7));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_data = '0; icc_we = 1'b0; icc_in = '0;
    trap_enter = 1'b0; trap_return = 1'b0;
    tick();
    t_reset();
    t_imm_and_delay();
    t_alu_icc();
    t_restart();
    t_trap_entry();
    t_trap_return();
    t_collision();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule